// File: doc/BRIEF.md
# Sequential Coefficient Memory Access Port

This block sits in front of a 512-word, 32-bit coefficient memory that a signal-processing datapath reads every cycle. Software never addresses the memory directly. It programs a command register with a start address, a direction and a sequential flag, and then moves words through a single data register. Each data register access uses the internal pointer. In sequential mode the pointer steps on to the next location after each access, so a table such as a set of signed gain-curve coefficients can be streamed in, or read back, with one command followed by a run of data accesses.

Writes to the memory are posted. A data register write is held in a one-entry pending slot and committed in a later cycle. While the slot is occupied, the command register shows a busy flag, and software polls this flag before it issues the next command. A datapath read has priority over the memory write port. If the datapath reads in the cycle a commit would happen, the commit waits, and busy stays set until the write lands.

Top module: `coefram_port`

## Requirements
- R1: After reset the command register reads 0x00004000, busy is clear, and both `bus_rdata` and `dp_rdata` are zero.
- R2: The command register fields are: address in bits 8:0, sequential flag in bit 12, pointer-load flag in bit 13, direction in bit 14 (1 = write, 0 = read), and busy in bit 31 (read-only). All other bits read as zero. A command write always updates the stored fields. It copies bits 8:0 into the pointer only when bit 13 is set.
- R3: In write direction, a data register write (`bus_sel` = 1) stores the word at the pointer, and the datapath later reads that word back unchanged, including negative values.
- R4: With the sequential flag set, the pointer advances by one after each accepted data write (write direction) and after each data read (read direction). With the flag clear, the pointer stays put and repeated writes overwrite the same location.
- R5: The pointer wraps from 511 to 0.
- R6: Busy reads as 1 in the cycle after a data write is accepted. When the datapath is idle, busy clears one cycle later.
- R7: While `dp_rd_en` is high, a pending write is not committed and busy stays set. The datapath reads the old contents. The write lands in the first cycle without a datapath read.
- R8: While busy is set, command and data register writes are ignored.
- R9: A data register write while the direction is read has no effect on the memory or the pointer, and it does not raise busy.
- R10: A bus read returns its value on `bus_rdata` one cycle after `bus_rd_en`, and the value holds until the next bus read. A data read returns the word at the pointer. A datapath read returns `mem[dp_addr]` on `dp_rdata` one cycle after `dp_rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered register read data |
| dp_rd_en | input | 1 | Datapath read request (priority over bus writes) |
| dp_addr | input | ADDR_W | Datapath read address |
| dp_rdata | output | DATA_W | Registered datapath read data |

## Verification
The bench builds the block with its defaults: a 9-bit address and a 32-bit word. With these values, the 511-to-0 pointer wrap is reached with a single command and two data writes. Full-width signed coefficients also travel through unchanged. Because the datapath read enable is held across several bus operations, the same configuration also reaches the cases where a commit is held off and busy blocks new commands.

// File: rtl/coefram_pkg.sv
package coefram_pkg;
    localparam int BUS_W        = 32;
    localparam int CTL_SEQ_BIT  = 12;
    localparam int CTL_LOAD_BIT = 13;
    localparam int CTL_DIR_BIT  = 14;
    localparam int CTL_BUSY_BIT = 31;
    localparam logic [BUS_W-1:0] CTL_RESET_VAL = 32'h0000_4000;

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/coefram_store.sv
module coefram_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rword,
    input  logic              dp_rd_en,
    input  logic [ADDR_W-1:0] dp_addr,
    output logic [DATA_W-1:0] dp_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] dp_d, dp_q;

    // storage array: no reset, written only by a granted commit
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign bus_rword = mem_q[bus_raddr];

    always_comb begin
        dp_d = dp_q;
        if (dp_rd_en) begin
            dp_d = mem_q[dp_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign dp_rdata = dp_q;
endmodule

// File: rtl/coefram_wr_arb.sv
module coefram_wr_arb (
    input  logic pend_valid,
    input  logic dp_rd_en,
    output logic mem_we
);
    // datapath reads own the array port; a posted bus write waits for a free cycle
    always_comb begin
        mem_we = pend_valid && !dp_rd_en;
    end
endmodule

// File: rtl/coefram_port_ctrl.sv
module coefram_port_ctrl
    import coefram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic              bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0] mem_word,
    input  logic              commit,
    output logic [ADDR_W-1:0] ptr,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic              cfg_write,
    output logic              cfg_seq
);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              seq;
        logic              load;
        logic              write;
        logic [ADDR_W-1:0] ptr;
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [BUS_W-1:0]  rdata;
    } state_t;

    state_t st_d, st_q;
    logic   cmd_wr, dat_wr, dat_rd;
    logic [BUS_W-1:0] cmd_view;

    always_comb begin
        st_d   = st_q;
        cmd_wr = bus_wr_en && (bus_sel == SEL_CMD) && !st_q.pend;
        dat_wr = bus_wr_en && (bus_sel == SEL_DATA) && !st_q.pend && st_q.write;
        dat_rd = bus_rd_en && (bus_sel == SEL_DATA);

        cmd_view = '0;
        cmd_view[ADDR_W-1:0]  = st_q.addr;
        cmd_view[CTL_SEQ_BIT]  = st_q.seq;
        cmd_view[CTL_LOAD_BIT] = st_q.load;
        cmd_view[CTL_DIR_BIT]  = st_q.write;
        cmd_view[CTL_BUSY_BIT] = st_q.pend;

        if (commit) begin
            st_d.pend = 1'b0;
        end

        if (dat_rd && !st_q.write && st_q.seq) begin
            st_d.ptr = st_q.ptr + PTR_ONE;
        end

        if (dat_wr) begin
            st_d.pend  = 1'b1;
            st_d.paddr = st_q.ptr;
            st_d.pdata = bus_wdata[DATA_W-1:0];
            if (st_q.seq) begin
                st_d.ptr = st_q.ptr + PTR_ONE;
            end
        end

        if (cmd_wr) begin
            st_d.addr  = bus_wdata[ADDR_W-1:0];
            st_d.seq   = bus_wdata[CTL_SEQ_BIT];
            st_d.load  = bus_wdata[CTL_LOAD_BIT];
            st_d.write = bus_wdata[CTL_DIR_BIT];
            if (bus_wdata[CTL_LOAD_BIT]) begin
                st_d.ptr = bus_wdata[ADDR_W-1:0];
            end
        end

        if (bus_rd_en) begin
            st_d.rdata = (bus_sel == SEL_CMD) ? cmd_view : BUS_W'(mem_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr  <= CTL_RESET_VAL[ADDR_W-1:0];
            st_q.seq   <= CTL_RESET_VAL[CTL_SEQ_BIT];
            st_q.load  <= CTL_RESET_VAL[CTL_LOAD_BIT];
            st_q.write <= CTL_RESET_VAL[CTL_DIR_BIT];
            st_q.ptr   <= '0;
            st_q.pend  <= 1'b0;
            st_q.paddr <= '0;
            st_q.pdata <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign ptr        = st_q.ptr;
    assign pend_valid = st_q.pend;
    assign pend_addr  = st_q.paddr;
    assign pend_data  = st_q.pdata;
    assign cfg_write  = st_q.write;
    assign cfg_seq    = st_q.seq;
endmodule

// File: rtl/coefram_port.sv
module coefram_port #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic              bus_sel,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dp_rd_en,
    input  logic [ADDR_W-1:0] dp_addr,
    output logic [DATA_W-1:0] dp_rdata
);
    logic [ADDR_W-1:0] ptr_w;
    logic [ADDR_W-1:0] paddr_w;
    logic [DATA_W-1:0] pdata_w;
    logic [DATA_W-1:0] mem_word_w;
    logic              busy_w;
    logic              mem_we_w;
    logic              cfg_write_w;
    logic              cfg_seq_w;

    coefram_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_en  (bus_wr_en),
        .bus_rd_en  (bus_rd_en),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .mem_word   (mem_word_w),
        .commit     (mem_we_w),
        .ptr        (ptr_w),
        .pend_valid (busy_w),
        .pend_addr  (paddr_w),
        .pend_data  (pdata_w),
        .cfg_write  (cfg_write_w),
        .cfg_seq    (cfg_seq_w)
    );

    coefram_wr_arb u_arb (
        .pend_valid (busy_w),
        .dp_rd_en   (dp_rd_en),
        .mem_we     (mem_we_w)
    );

    coefram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we_w),
        .waddr     (paddr_w),
        .wdata     (pdata_w),
        .bus_raddr (ptr_w),
        .bus_rword (mem_word_w),
        .dp_rd_en  (dp_rd_en),
        .dp_addr   (dp_addr),
        .dp_rdata  (dp_rdata)
    );
endmodule

// File: rtl/coefram_sva.sv
module coefram_sva #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic              bus_sel,
    input logic              dp_rd_en,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input logic              cfg_write,
    input logic              cfg_seq
);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PTR_TOP = '1;

    p_wr_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_sel && !busy && cfg_write) |=> busy);

    p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dp_rd_en) |=> !busy);

    p_dp_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !dp_rd_en);

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dp_rd_en) |=> busy);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr_en) |=> $stable(ptr));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_sel && !busy && cfg_write && cfg_seq && ptr == PTR_TOP)
        |=> (ptr == '0));

    p_seq_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_sel && !bus_wr_en && !cfg_write && cfg_seq)
        |=> (ptr == $past(ptr) + PTR_ONE));
endmodule

bind coefram_port coefram_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_sel   (bus_sel),
    .dp_rd_en  (dp_rd_en),
    .busy      (busy_w),
    .mem_we    (mem_we_w),
    .ptr       (ptr_w),
    .cfg_write (cfg_write_w),
    .cfg_seq   (cfg_seq_w)
);

// File: tb/tb_coefram_port.sv
module tb_coefram_port;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic              bus_rd_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              dp_rd_en = 1'b0;
    logic [ADDR_W-1:0] dp_addr = '0;
    logic [DATA_W-1:0] dp_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    coefram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dp_rd_en(dp_rd_en), .dp_addr(dp_addr), .dp_rdata(dp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmdv(input bit busy, input bit wr, input bit load,
                                         input bit seq, input int addr);
        return {busy, 16'b0, wr, load, seq, 3'b0, 9'(addr)};
    endfunction

    function automatic logic [31:0] coef(input int i);
        return 32'((i - 4) * 123457 - 77);
    endfunction

    task automatic bus_wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input bit sel, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_sel = sel;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic dp_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        dp_rd_en = 1'b1; dp_addr = ADDR_W'(a);
        @(negedge clk);
        dp_rd_en = 1'b0;
        d = dp_rdata;
    endtask

    task automatic cmd(input int addr, input bit wr, input bit load, input bit seq);
        bus_wr(1'b0, cmdv(1'b0, wr, load, seq, addr));
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 20; k++) begin
            bus_rd(1'b0, v);
            if (!v[31]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 bus_rdata after reset", bus_rdata, 32'h0);
        chk("R1 dp_rdata after reset", dp_rdata, 32'h0);
        bus_rd(1'b0, v);
        chk("R1 command reset value", v, 32'h0000_4000);
    endtask

    task automatic t_coef_load();
        logic [31:0] v;
        cmd(0, 1, 1, 1);
        for (int i = 0; i < 9; i++) bus_wr(1'b1, coef(i));
        wait_idle();
        for (int i = 0; i < 9; i++) begin
            dp_rd(i, v);
            chk("R3 signed coefficient via datapath", v, coef(i));
        end
        cmd(0, 0, 1, 1);
        for (int i = 0; i < 9; i++) begin
            bus_rd(1'b1, v);
            chk("R4 sequential readback", v, coef(i));
        end
    endtask

    task automatic t_fixed_addr();
        logic [31:0] v;
        cmd(21, 1, 1, 0);
        bus_wr(1'b1, 32'h2121_0021);
        cmd(20, 1, 1, 0);
        bus_wr(1'b1, 32'h1111_1111);
        bus_wr(1'b1, 32'h2222_2222);
        wait_idle();
        dp_rd(20, v);
        chk("R4 non-sequential overwrite", v, 32'h2222_2222);
        dp_rd(21, v);
        chk("R4 neighbour untouched", v, 32'h2121_0021);
    endtask

    task automatic t_no_load();
        logic [31:0] v;
        cmd(30, 1, 1, 1);
        bus_wr(1'b1, 32'hA5A5_0030);
        cmd(50, 1, 0, 1);
        bus_rd(1'b0, v);
        chk("R2 fields stored without load", v, cmdv(0, 1, 0, 1, 50));
        bus_wr(1'b1, 32'h5A5A_0031);
        wait_idle();
        dp_rd(31, v);
        chk("R2 pointer kept without load", v, 32'h5A5A_0031);
        dp_rd(30, v);
        chk("R3 first word", v, 32'hA5A5_0030);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        cmd(511, 1, 1, 1);
        bus_wr(1'b1, 32'hDEAD_01FF);
        bus_wr(1'b1, 32'hBEEF_0000);
        wait_idle();
        cmd(511, 0, 1, 1);
        bus_rd(1'b1, v);
        chk("R5 word at 511", v, 32'hDEAD_01FF);
        bus_rd(1'b1, v);
        chk("R5 wrapped to 0", v, 32'hBEEF_0000);
        dp_rd(0, v);
        chk("R5 datapath at 0", v, 32'hBEEF_0000);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        cmd(10, 1, 1, 0);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_sel = 1'b1; bus_wdata = 32'h0000_1010;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b1; bus_sel = 1'b0;
        @(negedge clk);
        chk("R6 busy after data write", bus_rdata, cmdv(1, 1, 1, 0, 10));
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk("R6 busy cleared after one cycle", bus_rdata, cmdv(0, 1, 1, 0, 10));
        repeat (3) @(negedge clk);
        chk("R10 read data holds", bus_rdata, cmdv(0, 1, 1, 0, 10));
        dp_rd(10, v);
        chk("R10 datapath latency", v, 32'h0000_1010);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        cmd(200, 1, 1, 1);
        bus_wr(1'b1, 32'hC0C0_0200);
        bus_wr(1'b1, 32'hC0C0_0201);
        wait_idle();
        cmd(200, 1, 1, 1);
        @(negedge clk);
        dp_rd_en = 1'b1; dp_addr = ADDR_W'(200);
        bus_wr(1'b1, 32'hEEEE_0200);
        bus_wr(1'b0, cmdv(0, 0, 1, 0, 300));
        bus_wr(1'b1, 32'hEEEE_0201);
        bus_rd(1'b0, v);
        chk("R7 busy held under datapath reads", v, cmdv(1, 1, 1, 1, 200));
        chk("R7 datapath sees old word", dp_rdata, 32'hC0C0_0200);
        @(negedge clk);
        dp_rd_en = 1'b0;
        bus_rd(1'b0, v);
        chk("R8 command unchanged while busy", v, cmdv(0, 1, 1, 1, 200));
        dp_rd(200, v);
        chk("R7 write landed after release", v, 32'hEEEE_0200);
        dp_rd(201, v);
        chk("R8 data write while busy ignored", v, 32'hC0C0_0201);
    endtask

    task automatic t_wrong_dir();
        logic [31:0] v;
        cmd(40, 1, 1, 0);
        bus_wr(1'b1, 32'h4040_4040);
        wait_idle();
        cmd(40, 0, 1, 1);
        bus_wr(1'b1, 32'hFFFF_FFFF);
        bus_rd(1'b0, v);
        chk("R9 no busy in read direction", v, cmdv(0, 0, 1, 1, 40));
        bus_rd(1'b1, v);
        chk("R9 memory and pointer unchanged", v, 32'h4040_4040);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_coef_load();
        t_fixed_addr();
        t_no_load();
        t_wrap();
        t_busy();
        t_priority();
        t_wrong_dir();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule